// File: doc/BRIEF.md
# Gray-Order Multi-Channel Latch Update Sequencer

This controller sits on the host side of an eight-channel addressable latch. That latch has a 3-bit channel address, a data bit, an active-low select and an active-low clear. While select is low, the latch is transparent for the channel whose address is driven. When select rises, the latch keeps the last data it saw. A low on clear turns every channel off.

A request carries an 8-bit channel mask and one target level. In the normal case the controller drops select once and steps the address in Gray order (0, 1, 3, 2, 6, 7, 5, 4) from the first masked channel to the last masked channel. Only one address bit changes per step, so no channel outside the walk is ever addressed along the way. Unmasked channels inside that span also get written. The controller keeps a copy of the level it last wrote to each channel, and allows this only when every such channel already holds the target level. When any of them does not, the controller writes the masked channels one at a time instead, each with its own select pulse.

Every minimum interval (setup, hold, select width, clear width) is given in nanoseconds. It is rounded up to whole clock cycles at the configured clock period.

Top module: `gray_update_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, select and clear are high (inactive), and busy and done are low.
- R2: Each address step while select is low changes exactly one address bit. The channels are visited in Gray order, where the channel at position i is i XOR (i>>1), running from the lowest masked position to the highest masked position.
- R3: A walk uses exactly one select low pulse, and data stays at the target level for the whole time select is low.
- R4: Address and data are unchanged for at least SETUP_CYC cycles before select falls. While select is low, each address is driven for at least SETUP_CYC cycles.
- R5: After select rises, address and data stay unchanged for at least HOLD_CYC cycles.
- R6: Every select low pulse lasts at least SEL_CYC cycles.
- R7: A clear request drives clear low for at least CLR_CYC cycles, with select high throughout. Afterwards every channel reads off.
- R8: When an unmasked channel inside the span was last written with a level other than the target, each masked channel gets its own select pulse in Gray order. No unmasked channel is addressed while select is low.
- R9: A request presented while busy is high is ignored.
- R10: After the hold interval, done is high for exactly one cycle. Busy stays high from acceptance until done.
- R11: A request with an empty mask and no clear pulses done on the next cycle. It drives no select pulse and changes no channel.
- R12: Each cycle count is the nanosecond figure divided by the clock period, rounded up. At the defaults (5 ns clock) this gives setup 80, hold 10, select width 100 and clear width 100 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_clear | input | 1 | Request is a clear of all channels; takes priority over the mask |
| req_mask | input | 8 | Channels to update, bit n is channel n |
| req_value | input | 1 | Target level for the masked channels |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| lat_addr | output | 3 | Channel address to the latch |
| lat_data | output | 1 | Data level to the latch |
| lat_sel_n | output | 1 | Active-low select to the latch |
| lat_clr_n | output | 1 | Active-low clear to the latch |

## Verification
The bound checker checks the following on every cycle:
- each address step under select changes a single bit;
- data stays put while select is low;
- the setup, hold, select-width and clear-width minimums are met;
- select and clear are never low together;
- done lasts one cycle, and busy covers every select pulse.

The following can only be shown by the bench scenarios, which run a model of the latch against the pins:
- the exact order of channels visited;
- the choice between one walk and separate single writes, which depends on what was written earlier;
- the final state of every channel;
- that requests made while busy or with an empty mask have no effect.

// File: rtl/gus_pkg.sv
package gus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SELECT,
    ST_HOLD,
    ST_CLEAR
  } gus_state_e;
endpackage

// File: rtl/gus_span.sv
module gus_span #(
  parameter int ADDR_W = 3
) (
  input  logic [(1<<ADDR_W)-1:0] mask,
  input  logic [(1<<ADDR_W)-1:0] shadow,
  input  logic                   value,
  output logic                   any,
  output logic [ADDR_W-1:0]      first_idx,
  output logic [ADDR_W-1:0]      last_idx,
  output logic                   fits
);
  localparam int NCH = 1 << ADDR_W;

  function automatic logic [ADDR_W-1:0] gray(input logic [ADDR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign any = |mask;

  always_comb begin
    first_idx = '0;
    last_idx  = '0;
    fits      = 1'b1;
    for (int i = NCH - 1; i >= 0; i--)
      if (mask[gray(ADDR_W'(i))]) first_idx = ADDR_W'(i);
    for (int i = 0; i < NCH; i++)
      if (mask[gray(ADDR_W'(i))]) last_idx = ADDR_W'(i);
    for (int i = 0; i < NCH; i++)
      if (ADDR_W'(i) >= first_idx && ADDR_W'(i) <= last_idx &&
          !mask[gray(ADDR_W'(i))] && shadow[gray(ADDR_W'(i))] != value)
        fits = 1'b0;
  end
endmodule

// File: rtl/gus_timer.sv
module gus_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/gray_update_seq.sv
module gray_update_seq #(
  parameter int CLK_PS   = 5000,
  parameter int SETUP_NS = 400,
  parameter int HOLD_NS  = 50,
  parameter int SEL_NS   = 500,
  parameter int CLR_NS   = 500,
  parameter int ADDR_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_clear,
  input  logic [(1<<ADDR_W)-1:0] req_mask,
  input  logic                   req_value,
  output logic                   busy,
  output logic                   done,
  output logic [ADDR_W-1:0]      lat_addr,
  output logic                   lat_data,
  output logic                   lat_sel_n,
  output logic                   lat_clr_n
);
  import gus_pkg::*;

  localparam int NCH       = 1 << ADDR_W;
  localparam int SETUP_RAW = (SETUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_RAW  = (HOLD_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int SEL_RAW   = (SEL_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CLR_RAW   = (CLR_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int HOLD_CYC  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int SEL_CYC   = (SEL_RAW < 1) ? 1 : SEL_RAW;
  localparam int CLR_CYC   = (CLR_RAW < 1) ? 1 : CLR_RAW;
  localparam int MAX_AB    = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_CD    = (SEL_CYC > CLR_CYC) ? SEL_CYC : CLR_CYC;
  localparam int MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TW        = $clog2(MAX_CYC + 1);

  localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] T_CLR   = TW'(CLR_CYC - 1);
  localparam logic [TW-1:0] P_DONE  = TW'(SEL_CYC - 1);

  function automatic logic [ADDR_W-1:0] gray(input logic [ADDR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  gus_state_e        state;
  logic [ADDR_W-1:0] idx, last_idx;
  logic              fallback;
  logic [NCH-1:0]    mask_r, shadow;
  logic              value_r;
  logic [TW-1:0]     pcnt;

  logic [NCH-1:0]    span_mask;
  logic              span_any, span_fits;
  logic [ADDR_W-1:0] span_first, span_last;
  logic              tmr_load, tmr_exp;
  logic [TW-1:0]     tmr_val;
  logic              accept, at_last, width_ok;

  assign span_mask = (state == ST_IDLE) ? req_mask : mask_r;
  assign accept    = (state == ST_IDLE) && req_valid;
  assign at_last   = (idx == last_idx);
  assign width_ok  = (pcnt >= P_DONE);

  gus_span #(.ADDR_W(ADDR_W)) u_span (
    .mask      (span_mask),
    .shadow    (shadow),
    .value     (state == ST_IDLE ? req_value : value_r),
    .any       (span_any),
    .first_idx (span_first),
    .last_idx  (span_last),
    .fits      (span_fits)
  );

  gus_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (req_clear) begin
          tmr_load = 1'b1; tmr_val = T_CLR;
        end else if (span_any) begin
          tmr_load = 1'b1; tmr_val = T_SETUP;
        end
      end
      ST_SETUP: if (tmr_exp) begin
        tmr_load = 1'b1; tmr_val = T_SETUP;
      end
      ST_SELECT: if (tmr_exp) begin
        if (!at_last) begin
          tmr_load = 1'b1; tmr_val = T_SETUP;
        end else if (width_ok) begin
          tmr_load = 1'b1; tmr_val = T_HOLD;
        end
      end
      ST_HOLD: if (tmr_exp && fallback && span_any) begin
        tmr_load = 1'b1; tmr_val = T_SETUP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      last_idx  <= '0;
      fallback  <= 1'b0;
      mask_r    <= '0;
      shadow    <= '0;
      value_r   <= 1'b0;
      pcnt      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= 1'b0;
      lat_sel_n <= 1'b1;
      lat_clr_n <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (req_clear) begin
            lat_clr_n <= 1'b0;
            busy      <= 1'b1;
            state     <= ST_CLEAR;
          end else if (span_any) begin
            idx      <= span_first;
            last_idx <= span_fits ? span_last : span_first;
            fallback <= !span_fits;
            mask_r   <= req_mask;
            value_r  <= req_value;
            lat_addr <= gray(span_first);
            lat_data <= req_value;
            busy     <= 1'b1;
            state    <= ST_SETUP;
          end else begin
            done <= 1'b1;
          end
        end
        ST_SETUP: if (tmr_exp) begin
          lat_sel_n <= 1'b0;
          pcnt      <= '0;
          state     <= ST_SELECT;
        end
        ST_SELECT: begin
          shadow[lat_addr] <= lat_data;
          if (!width_ok) pcnt <= pcnt + 1'b1;
          if (tmr_exp) begin
            if (!at_last) begin
              idx      <= idx + 1'b1;
              lat_addr <= gray(idx + 1'b1);
            end else if (width_ok) begin
              lat_sel_n        <= 1'b1;
              mask_r[lat_addr] <= 1'b0;
              state            <= ST_HOLD;
            end
          end
        end
        ST_HOLD: if (tmr_exp) begin
          if (fallback && span_any) begin
            idx      <= span_first;
            last_idx <= span_first;
            lat_addr <= gray(span_first);
            state    <= ST_SETUP;
          end else begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_CLEAR: begin
          shadow <= '0;
          if (tmr_exp) begin
            lat_clr_n <= 1'b1;
            busy      <= 1'b0;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gus_checker.sv
module gus_checker #(
  parameter int CLK_PS   = 5000,
  parameter int SETUP_NS = 400,
  parameter int HOLD_NS  = 50,
  parameter int SEL_NS   = 500,
  parameter int CLR_NS   = 500,
  parameter int ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] lat_addr,
  input logic              lat_data,
  input logic              lat_sel_n,
  input logic              lat_clr_n
);
  localparam int SETUP_RAW = (SETUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_RAW  = (HOLD_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int SEL_RAW   = (SEL_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CLR_RAW   = (CLR_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int HOLD_CYC  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int SEL_CYC   = (SEL_RAW < 1) ? 1 : SEL_RAW;
  localparam int CLR_CYC   = (CLR_RAW < 1) ? 1 : CLR_RAW;

  logic [ADDR_W-1:0] addr_d;
  logic              data_d;
  logic [15:0]       stab_cnt, low_cnt, clr_cnt, since_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_d <= '0; data_d <= 1'b0;
      stab_cnt <= '0; low_cnt <= '0; clr_cnt <= '0; since_rise <= 16'hFFFF;
    end else begin
      addr_d <= lat_addr;
      data_d <= lat_data;
      if (lat_addr != addr_d || lat_data != data_d) stab_cnt <= 16'd1;
      else if (stab_cnt != 16'hFFFF)                stab_cnt <= stab_cnt + 1'b1;
      if (!lat_sel_n) low_cnt <= low_cnt + 1'b1; else low_cnt <= '0;
      if (!lat_clr_n) clr_cnt <= clr_cnt + 1'b1; else clr_cnt <= '0;
      if (!lat_sel_n)                  since_rise <= '0;
      else if (since_rise != 16'hFFFF) since_rise <= since_rise + 1'b1;
    end
  end

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!lat_sel_n && $past(!lat_sel_n) && !$stable(lat_addr)) |->
      $countones(lat_addr ^ $past(lat_addr)) == 1);  // R2
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!lat_sel_n && $past(!lat_sel_n)) |-> $stable(lat_data));  // R3
  AST_SETUP_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(lat_sel_n) |-> stab_cnt >= 16'(SETUP_CYC));  // R4
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (rst)
    (lat_sel_n && (lat_addr != addr_d || lat_data != data_d)) |->
      since_rise >= 16'(HOLD_CYC));  // R5
  AST_SEL_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_sel_n) |-> low_cnt >= 16'(SEL_CYC));  // R6
  AST_CLR_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_clr_n) |-> clr_cnt >= 16'(CLR_CYC));  // R7
  AST_NO_SEL_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !lat_clr_n |-> lat_sel_n);  // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R10
  AST_BUSY_COVERS_SEL: assert property (@(posedge clk) disable iff (rst)
    !lat_sel_n |-> busy);  // R10
endmodule

bind gray_update_seq gus_checker #(
  .CLK_PS(CLK_PS), .SETUP_NS(SETUP_NS), .HOLD_NS(HOLD_NS),
  .SEL_NS(SEL_NS), .CLR_NS(CLR_NS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .lat_addr(lat_addr),
  .lat_data(lat_data), .lat_sel_n(lat_sel_n), .lat_clr_n(lat_clr_n)
);

// File: tb/gray_update_seq_test.sv
`timescale 1ns/1ps
module gray_update_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_clear = 1'b0, req_value = 1'b0;
  logic [7:0] req_mask = '0;
  logic       busy, done, lat_data, lat_sel_n, lat_clr_n;
  logic [2:0] lat_addr;

  always #2.5 clk = ~clk;

  gray_update_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_clear(req_clear),
    .req_mask(req_mask), .req_value(req_value), .busy(busy), .done(done),
    .lat_addr(lat_addr), .lat_data(lat_data), .lat_sel_n(lat_sel_n),
    .lat_clr_n(lat_clr_n)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // latch model and per-operation observations, sampled at negedge
  logic [7:0] model = '0;
  logic [2:0] order [16];
  int n_order, n_falls, n_clr, data_bad, busy_bad;
  int min_setup = 99999, min_width = 99999, min_hold = 99999, min_clr = 99999;
  int stab = 0, low = 0, clow = 0, since = 99999;
  logic prev_sel = 1'b1, prev_clr = 1'b1, hold_pend = 1'b0, exp_data;
  logic [2:0] prev_addr = '0;
  logic prev_data = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (lat_addr != prev_addr || lat_data != prev_data) begin
        if (hold_pend && lat_sel_n) begin
          if (since < min_hold) min_hold = since;
          hold_pend = 1'b0;
        end
        stab = 1;
      end else stab++;
      if (!lat_clr_n) model = '0;
      else if (!lat_sel_n) model[lat_addr] = lat_data;
      if (!lat_sel_n) begin
        if (prev_sel) begin
          n_falls++;
          if (stab - 1 < min_setup) min_setup = stab - 1;
        end
        if (prev_sel || lat_addr != prev_addr) begin
          if (n_order < 16) order[n_order] = lat_addr;
          n_order++;
        end
        if (lat_data != exp_data) data_bad++;
        if (!busy) busy_bad++;
        low++;
      end else if (!prev_sel) begin
        if (low < min_width) min_width = low;
        low = 0; since = 0; hold_pend = 1'b1;
      end
      if (lat_sel_n) since++;
      if (!lat_clr_n) begin
        if (prev_clr) n_clr++;
        clow++;
      end else if (!prev_clr) begin
        if (clow < min_clr) min_clr = clow;
        clow = 0;
      end
      prev_sel = lat_sel_n; prev_clr = lat_clr_n;
      prev_addr = lat_addr; prev_data = lat_data;
    end
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // issue one request, optionally a second one while busy, wait for done
  task automatic run_op(input logic clr, input logic [7:0] m, input logic v,
                        input bit poke, input string req);
    int wait_cyc = 0, done_len = 0;
    bit saw_busy = 0;
    n_order = 0; n_falls = 0; n_clr = 0; data_bad = 0; busy_bad = 0;
    exp_data = v;
    @(negedge clk);
    req_valid = 1'b1; req_clear = clr; req_mask = m; req_value = v;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      saw_busy = busy;
      req_valid = 1'b1; req_clear = 1'b1; req_mask = 8'hFF; req_value = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_clear = 1'b0;
    end
    while (!done && wait_cyc < 20000) begin
      if (busy) saw_busy = 1;
      @(negedge clk);
      wait_cyc++;
    end
    while (done) begin done_len++; @(negedge clk); end
    check(done_len == 1, "R10", "done pulse length", done_len, 1);
    check(busy == 1'b0, "R10", "busy after done", busy, 0);
    if (m != 0 || clr) check(saw_busy, "R10", "busy seen during op", saw_busy, 1);
    check(busy_bad == 0, "R10", "select without busy", busy_bad, 0);
    if (!clr) check(data_bad == 0, "R3", "data off target under select", data_bad, 0);
    if (!clr) check(n_clr == 0, "R9", "clear pulses", n_clr, 0);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [2:0] g(input int i);
    logic [2:0] b = 3'(i);
    return b ^ (b >> 1);
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(lat_sel_n && lat_clr_n && !busy && !done, "R1", "outputs in reset",
          {lat_sel_n, lat_clr_n, busy, done}, 4'b1100);
    rst = 1'b0;
    @(negedge clk);
    check(lat_sel_n && lat_clr_n && !busy && !done, "R1", "outputs after reset",
          {lat_sel_n, lat_clr_n, busy, done}, 4'b1100);
  endtask

  task automatic t_clear;
    model = 8'h5A;
    run_op(1'b1, 8'h00, 1'b0, 0, "R7");
    check(n_clr == 1, "R7", "clear pulses", n_clr, 1);
    check(n_falls == 0, "R7", "select pulses in clear", n_falls, 0);
    check(model == 8'h00, "R7", "channels after clear", model, 0);
  endtask

  task automatic t_single;
    run_op(1'b0, 8'h20, 1'b1, 0, "R6");
    check(n_falls == 1, "R6", "single write pulses", n_falls, 1);
    check(n_order == 1 && order[0] == 3'd5, "R2", "single write address",
          order[0], 5);
    check(model == 8'h20, "R6", "channels after single write", model, 8'h20);
  endtask

  task automatic t_walk_all;
    bit ok = 1;
    run_op(1'b0, 8'hFF, 1'b1, 0, "R3");
    check(n_falls == 1, "R3", "walk select pulses", n_falls, 1);
    check(n_order == 8, "R2", "walk length", n_order, 8);
    for (int i = 0; i < 8; i++) if (order[i] != g(i)) ok = 0;
    check(ok, "R2", "walk order 0,1,3,2,6,7,5,4", order[3], 2);
    check(model == 8'hFF, "R3", "channels after walk", model, 8'hFF);
  endtask

  task automatic t_fallback;
    run_op(1'b0, 8'h28, 1'b0, 0, "R8");
    check(n_falls == 2, "R8", "separate pulses", n_falls, 2);
    check(n_order == 2 && order[0] == 3'd3 && order[1] == 3'd5, "R8",
          "only masked channels addressed", order[1], 5);
    check(model == 8'hD7, "R8", "channels after split writes", model, 8'hD7);
  endtask

  task automatic t_partial_walk;
    bit ok;
    run_op(1'b0, 8'h28, 1'b1, 0, "R2");
    ok = (n_order == 5);
    for (int i = 0; i < 5; i++) if (order[i] != g(i + 2)) ok = 0;
    check(n_falls == 1, "R3", "partial walk pulses", n_falls, 1);
    check(ok, "R2", "partial walk order 3,2,6,7,5", n_order, 5);
    check(model == 8'hFF, "R2", "channels after partial walk", model, 8'hFF);
  endtask

  task automatic t_empty;
    run_op(1'b0, 8'h00, 1'b1, 0, "R11");
    check(n_falls == 0, "R11", "empty mask select pulses", n_falls, 0);
    check(model == 8'hFF, "R11", "channels after empty mask", model, 8'hFF);
  endtask

  task automatic t_busy_ignore;
    run_op(1'b0, 8'h01, 1'b0, 1, "R9");
    check(n_falls == 1, "R9", "pulses with request while busy", n_falls, 1);
    check(model == 8'hFE, "R9", "channels after ignored request", model, 8'hFE);
  endtask

  task automatic t_timing;
    check(min_setup >= 80, "R4", "min setup cycles", min_setup, 80);
    check(min_setup <= 81, "R12", "setup rounded to 80", min_setup, 80);
    check(min_hold >= 10, "R5", "min hold cycles", min_hold, 10);
    check(min_width >= 100, "R6", "min select width", min_width, 100);
    check(min_clr >= 100, "R7", "min clear width", min_clr, 100);
  endtask

  initial begin
    t_reset();
    t_clear();
    t_single();
    t_walk_all();
    t_fallback();
    t_partial_walk();
    t_empty();
    t_busy_ignore();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule